// File: doc/BRIEF.md
# Load/Store Byte Lane Aligner

This block sits between a processor's load/store stage and a 32-bit word-organized data memory. For every request it splits the byte address into a word address and an offset. It also checks that the offset suits the access size. A store request produces byte-lane write enables and lane-positioned write data, so a byte or halfword store changes only the addressed bytes of the memory word. A load request has its offset, size, signedness and byte order captured when the memory read is issued. When the read word comes back on the next cycle, the addressed bytes are picked out and sign- or zero-extended to 32 bits.

Byte order is chosen per request by an input. In little-endian order, the byte at a word's address sits in the least significant lane. In big-endian order, it sits in the most significant lane. Requests with a bad offset raise a misalign flag and reach the memory neither as a read nor as a write.

Top module: `lsa_lane_aligner`

## Requirements
- R1: Size codes are 0 = byte, 1 = halfword, 2 = word and 3 = reserved. With req_valid_i high, misalign_o is 1 in the same cycle for a halfword with address bit 0 set, for a word with address bits [1:0] nonzero, and for size 3. A byte access is never misaligned. A misaligned request drives mem_req_o low and mem_be_o to 0000.
- R2: mem_word_addr_o always equals req_addr_i[ADDR_W-1:2]. mem_req_o is high exactly when req_valid_i is high and the request is aligned, and mem_we_o follows req_we_i.
- R3: Lane k is mem_wdata_o[8k+7:8k] and is enabled by mem_be_o[k]. A byte store at offset o enables only lane o in little-endian order and only lane 3-o in big-endian order (big_endian_i = 1). mem_wdata_o carries the store byte in all four lanes.
- R4: A halfword store enables two lanes. Little-endian offset 0 gives 0011 and offset 2 gives 1100. Big-endian offset 0 gives 1100 and offset 2 gives 0011. mem_wdata_o carries the halfword in both halves, so the byte at the lower address lands in the lower-addressed lane.
- R5: A word store enables 1111 and passes req_wdata_i unchanged in either byte order.
- R6: A load request (req_we_i = 0) drives mem_be_o to 0000.
- R7: One cycle after an aligned byte load, load_valid_o is 1 and load_data_o holds the addressed byte, taken from the lane given in R3. It is sign-extended when req_signed_i was 1 and zero-extended otherwise.
- R8: One cycle after an aligned halfword load, load_data_o holds the halfword assembled in the request's byte order: big-endian puts the lower-addressed byte at bits 15:8, little-endian puts it at bits 7:0. The halfword is sign- or zero-extended as in R7.
- R9: One cycle after an aligned word load, load_data_o equals mem_rdata_i unchanged.
- R10: load_valid_o is high only in the cycle after an aligned load request. Stores, misaligned requests and idle cycles never raise it, and load_data_o is 0 whenever load_valid_o is 0.
- R11: While rst_ni is low and after its release with no request, load_valid_o is 0.
- R12: The offset, size, signedness and byte order of a load are captured with the request. A change of big_endian_i in the response cycle does not alter load_data_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request present this cycle |
| req_we_i | input | 1 | 1 = store, 0 = load |
| req_addr_i | input | ADDR_W | Byte address |
| req_size_i | input | 2 | 0 byte, 1 halfword, 2 word, 3 reserved |
| req_signed_i | input | 1 | Sign-extend narrow loads |
| big_endian_i | input | 1 | 1 = big-endian byte order |
| req_wdata_i | input | 32 | Store data, right-justified |
| mem_req_o | output | 1 | Aligned access issued to memory |
| mem_we_o | output | 1 | Memory write |
| mem_word_addr_o | output | ADDR_W-2 | Word address |
| mem_be_o | output | 4 | Byte-lane write enables |
| mem_wdata_o | output | 32 | Lane-positioned write data |
| misalign_o | output | 1 | Request offset illegal for its size |
| mem_rdata_i | input | 32 | Memory read word, one cycle after mem_req_o |
| load_valid_o | output | 1 | Load result valid |
| load_data_o | output | 32 | Aligned, extended load result |

## Verification
The store and alignment paths have no state, so a wrong lane mapping shows in the same cycle as the request, on mem_be_o or mem_wdata_o. A wrong captured load context has a delayed effect. A corrupted offset, size, sign or byte-order field appears one cycle later as a wrong byte choice or a wrong upper fill in load_data_o. A stale valid flag shows as load_valid_o rising after a store, a misaligned request or an idle cycle. The byte-order hold test flips the order input in the response cycle, so a context taken from the live input instead of the register shows as a wrong result.

// File: rtl/lsa_pkg.sv
package lsa_pkg;
  localparam int unsigned LANE_W = 8;
  localparam int unsigned LANES  = 4;
  localparam int unsigned WORD_W = LANE_W * LANES;
  localparam int unsigned OFF_W  = $clog2(LANES);

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } acc_size_e;

  typedef struct packed {
    logic [OFF_W-1:0] off;
    acc_size_e        size;
    logic             sext;
    logic             big;
  } ld_ctx_t;

  // byte offset -> physical lane; big-endian mirrors the lane order
  function automatic logic [OFF_W-1:0] lane_of(logic [OFF_W-1:0] off, logic big);
    return off ^ {OFF_W{big}};
  endfunction

  // halfword offset -> physical half (0 = low lanes)
  function automatic logic half_of(logic [OFF_W-1:0] off, logic big);
    return off[OFF_W-1] ^ big;
  endfunction
endpackage

// File: rtl/lsa_addr_check.sv
module lsa_addr_check
  import lsa_pkg::*;
(
  input  acc_size_e        size_i,
  input  logic [OFF_W-1:0] off_i,
  output logic             misalign_o
);
  always_comb begin
    unique case (size_i)
      SZ_BYTE: misalign_o = 1'b0;
      SZ_HALF: misalign_o = off_i[0];
      SZ_WORD: misalign_o = |off_i;
      default: misalign_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/lsa_store_lanes.sv
module lsa_store_lanes
  import lsa_pkg::*;
(
  input  logic              en_i,
  input  acc_size_e         size_i,
  input  logic [OFF_W-1:0]  off_i,
  input  logic              big_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic [LANES-1:0]  be_o,
  output logic [WORD_W-1:0] wdata_o
);
  logic [OFF_W-1:0] byte_lane;
  logic             half_sel;

  assign byte_lane = lane_of(off_i, big_i);
  assign half_sel  = half_of(off_i, big_i);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    localparam int unsigned HALF_IDX = g / 2;
    localparam int unsigned IN_HALF  = g % 2;
    logic hit;

    always_comb begin
      unique case (size_i)
        SZ_BYTE: hit = (byte_lane == OFF_W'(g));
        SZ_HALF: hit = (half_sel == HALF_IDX[0]);
        SZ_WORD: hit = 1'b1;
        default: hit = 1'b0;
      endcase
    end

    assign be_o[g] = en_i & hit;

    always_comb begin
      unique case (size_i)
        SZ_BYTE: wdata_o[g*LANE_W +: LANE_W] = wdata_i[LANE_W-1:0];
        SZ_HALF: wdata_o[g*LANE_W +: LANE_W] = wdata_i[IN_HALF*LANE_W +: LANE_W];
        default: wdata_o[g*LANE_W +: LANE_W] = wdata_i[g*LANE_W +: LANE_W];
      endcase
    end
  end
endmodule

// File: rtl/lsa_load_extract.sv
module lsa_load_extract
  import lsa_pkg::*;
(
  input  logic              valid_i,
  input  ld_ctx_t           ctx_i,
  input  logic [WORD_W-1:0] rdata_i,
  output logic [WORD_W-1:0] data_o
);
  localparam int unsigned HALF_W = 2 * LANE_W;

  logic [LANE_W-1:0] byte_v;
  logic [HALF_W-1:0] half_v;

  assign byte_v = rdata_i[lane_of(ctx_i.off, ctx_i.big)*LANE_W +: LANE_W];
  assign half_v = rdata_i[half_of(ctx_i.off, ctx_i.big)*HALF_W +: HALF_W];

  always_comb begin
    data_o = '0;
    if (valid_i) begin
      unique case (ctx_i.size)
        SZ_BYTE: data_o = {{(WORD_W-LANE_W){ctx_i.sext & byte_v[LANE_W-1]}}, byte_v};
        SZ_HALF: data_o = {{(WORD_W-HALF_W){ctx_i.sext & half_v[HALF_W-1]}}, half_v};
        default: data_o = rdata_i;
      endcase
    end
  end
endmodule

// File: rtl/lsa_lane_aligner.sv
module lsa_lane_aligner
  import lsa_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_we_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [1:0]        req_size_i,
  input  logic              req_signed_i,
  input  logic              big_endian_i,
  input  logic [31:0]       req_wdata_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-3:0] mem_word_addr_o,
  output logic [3:0]        mem_be_o,
  output logic [31:0]       mem_wdata_o,
  output logic              misalign_o,
  input  logic [31:0]       mem_rdata_i,
  output logic              load_valid_o,
  output logic [31:0]       load_data_o
);
  acc_size_e        size;
  logic [OFF_W-1:0] off;
  logic             bad;
  logic             ok;
  ld_ctx_t          ctx_q;
  logic             ld_q;

  assign size = acc_size_e'(req_size_i);
  assign off  = req_addr_i[OFF_W-1:0];

  lsa_addr_check i_chk (
    .size_i    (size),
    .off_i     (off),
    .misalign_o(bad)
  );

  assign ok              = req_valid_i & ~bad;
  assign misalign_o      = req_valid_i & bad;
  assign mem_req_o       = ok;
  assign mem_we_o        = req_we_i;
  assign mem_word_addr_o = req_addr_i[ADDR_W-1:OFF_W];

  lsa_store_lanes i_st (
    .en_i   (ok & req_we_i),
    .size_i (size),
    .off_i  (off),
    .big_i  (big_endian_i),
    .wdata_i(req_wdata_i),
    .be_o   (mem_be_o),
    .wdata_o(mem_wdata_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ld_q  <= 1'b0;
      ctx_q <= '0;
    end else begin
      ld_q <= ok & ~req_we_i;
      if (ok & ~req_we_i) begin
        ctx_q.off  <= off;
        ctx_q.size <= size;
        ctx_q.sext <= req_signed_i;
        ctx_q.big  <= big_endian_i;
      end
    end
  end

  lsa_load_extract i_ld (
    .valid_i(ld_q),
    .ctx_i  (ctx_q),
    .rdata_i(mem_rdata_i),
    .data_o (load_data_o)
  );

  assign load_valid_o = ld_q;
endmodule

// File: rtl/lsa_lane_aligner_chk.sv
module lsa_lane_aligner_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        req_valid_i,
  input logic        req_we_i,
  input logic [1:0]  req_size_i,
  input logic        mem_req_o,
  input logic [3:0]  mem_be_o,
  input logic        misalign_o,
  input logic        load_valid_o,
  input logic [31:0] load_data_o
);
  // R1
  misalign_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    misalign_o |-> (!mem_req_o && mem_be_o == 4'b0000));
  // R1
  rsvd_size_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_size_i == 2'd3) |-> misalign_o);
  // R6
  load_no_be_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_we_i |-> mem_be_o == 4'b0000);
  // R3
  byte_one_lane_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && req_we_i && req_size_i == 2'd0) |-> $countones(mem_be_o) == 1);
  // R4
  half_two_lane_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && req_we_i && req_size_i == 2'd1) |-> $countones(mem_be_o) == 2);
  // R10
  load_valid_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && (req_we_i || misalign_o)) |=> !load_valid_o);
  // R10
  idle_data_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_valid_o |-> load_data_o == 32'd0);
  // R11
  always_comb begin
    if (!rst_ni) reset_idle_chk: assert (!load_valid_o);
  end
endmodule

bind lsa_lane_aligner lsa_lane_aligner_chk i_lsa_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_we_i    (req_we_i),
  .req_size_i  (req_size_i),
  .mem_req_o   (mem_req_o),
  .mem_be_o    (mem_be_o),
  .misalign_o  (misalign_o),
  .load_valid_o(load_valid_o),
  .load_data_o (load_data_o)
);

// File: tb/test_lsa_lane_aligner.sv
module test_lsa_lane_aligner;
  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          valid = 1'b0, we = 1'b0, sgn = 1'b0, big = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [1:0]    size = 2'd0;
  logic [31:0]   wdata = '0, rdata = '0;
  logic          mem_req, mem_we, misalign, ld_valid;
  logic [AW-3:0] waddr;
  logic [3:0]    be;
  logic [31:0]   mwdata, ld_data;
  int            n_run = 0, n_fail = 0;

  always #4 clk = ~clk;

  lsa_lane_aligner #(.ADDR_W(AW)) i_lsa_lane_aligner (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(valid), .req_we_i(we),
    .req_addr_i(addr), .req_size_i(size), .req_signed_i(sgn),
    .big_endian_i(big), .req_wdata_i(wdata), .mem_req_o(mem_req),
    .mem_we_o(mem_we), .mem_word_addr_o(waddr), .mem_be_o(be),
    .mem_wdata_o(mwdata), .misalign_o(misalign), .mem_rdata_i(rdata),
    .load_valid_o(ld_valid), .load_data_o(ld_data)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic int lane(int a, bit b);
    return b ? 3 - a : a;
  endfunction

  function automatic logic [7:0] byte_at(logic [31:0] w, int a, bit b);
    return w[8*lane(a, b) +: 8];
  endfunction

  task automatic drive(bit v, bit w, logic [AW-1:0] a, logic [1:0] s, bit sg, bit b, logic [31:0] d);
    @(negedge clk);
    valid = v; we = w; addr = a; size = s; sgn = sg; big = b; wdata = d;
    #2;
  endtask

  task automatic idle();
    @(negedge clk);
    valid = 1'b0; we = 1'b0;
    #2;
  endtask

  task automatic t_reset();
    chk("R11 reset", {31'd0, ld_valid}, 32'd0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk); #2;
    chk("R11 after release", {31'd0, ld_valid}, 32'd0);
    chk("R10 idle data", ld_data, 32'd0);
  endtask

  task automatic t_store_byte();
    for (int b = 0; b < 2; b++)
      for (int o = 0; o < 4; o++) begin
        drive(1, 1, 32'h1000_0040 + o, 2'd0, 0, b[0], 32'hABCD_EF5A);
        chk("R3 be", {28'd0, be}, 32'd1 << lane(o, b[0]));
        chk("R3 data", mwdata, {4{8'h5A}});
        chk("R2 addr", {2'b0, waddr}, 32'h0400_0010);
        chk("R2 req", {30'd0, mem_req, mem_we}, 32'd3);
      end
    idle();
  endtask

  task automatic t_store_half();
    for (int b = 0; b < 2; b++)
      for (int o = 0; o < 4; o += 2) begin
        logic [3:0] e;
        e = '0;
        e[lane(o, b[0])] = 1'b1;
        e[lane(o + 1, b[0])] = 1'b1;
        drive(1, 1, 32'h0000_0200 + o, 2'd1, 0, b[0], 32'h1111_C3D4);
        chk("R4 be", {28'd0, be}, {28'd0, e});
        chk("R4 data", mwdata, 32'hC3D4_C3D4);
        // lower address must carry the byte that byte order puts there
        chk("R4 low addr byte", {24'd0, mwdata[8*lane(o, b[0]) +: 8]},
            {24'd0, b[0] ? 8'hC3 : 8'hD4});
      end
    idle();
  endtask

  task automatic t_store_word();
    for (int b = 0; b < 2; b++) begin
      drive(1, 1, 32'h0000_0300, 2'd2, 0, b[0], 32'h0123_4567);
      chk("R5 be", {28'd0, be}, 32'hF);
      chk("R5 data", mwdata, 32'h0123_4567);
    end
    idle();
  endtask

  task automatic t_misalign();
    drive(1, 1, 32'h0000_0101, 2'd1, 0, 0, 32'h0);
    chk("R1 half odd", {29'd0, misalign, mem_req, |be}, 32'b100);
    drive(1, 1, 32'h0000_0102, 2'd2, 0, 1, 32'h0);
    chk("R1 word off2", {29'd0, misalign, mem_req, |be}, 32'b100);
    drive(1, 0, 32'h0000_0100, 2'd3, 0, 0, 32'h0);
    chk("R1 rsvd", {30'd0, misalign, mem_req}, 32'b10);
    drive(1, 1, 32'h0000_0103, 2'd0, 0, 0, 32'h0);
    chk("R1 byte never", {30'd0, misalign, mem_req}, 32'b01);
    drive(1, 0, 32'h0000_0103, 2'd2, 0, 0, 32'h0);
    idle();
    chk("R10 no valid after misalign", {31'd0, ld_valid}, 32'd0);
    drive(1, 1, 32'h0000_0100, 2'd2, 0, 0, 32'h0);
    idle();
    chk("R10 no valid after store", {31'd0, ld_valid}, 32'd0);
    chk("R10 data zero", ld_data, 32'd0);
  endtask

  task automatic t_load_byte();
    rdata = 32'h8A7C_F135;
    for (int b = 0; b < 2; b++)
      for (int s = 0; s < 2; s++)
        for (int o = 0; o < 4; o++) begin
          logic [7:0] v;
          drive(1, 0, 32'h0000_0400 + o, 2'd0, s[0], b[0], 32'h0);
          chk("R6 load be", {28'd0, be}, 32'd0);
          v = byte_at(rdata, o, b[0]);
          idle();
          chk("R7 valid", {31'd0, ld_valid}, 32'd1);
          chk("R7 data", ld_data, {{24{s[0] & v[7]}}, v});
        end
  endtask

  task automatic t_load_half();
    rdata = 32'h9F2E_6B81;
    for (int b = 0; b < 2; b++)
      for (int s = 0; s < 2; s++)
        for (int o = 0; o < 4; o += 2) begin
          logic [15:0] h;
          drive(1, 0, 32'h0000_0500 + o, 2'd1, s[0], b[0], 32'h0);
          h = b[0] ? {byte_at(rdata, o, 1), byte_at(rdata, o + 1, 1)}
                   : {byte_at(rdata, o + 1, 0), byte_at(rdata, o, 0)};
          idle();
          chk("R8 data", ld_data, {{16{s[0] & h[15]}}, h});
        end
  endtask

  task automatic t_load_word();
    rdata = 32'hDEAD_B0EF;
    for (int b = 0; b < 2; b++) begin
      drive(1, 0, 32'h0000_0600, 2'd2, 1, b[0], 32'h0);
      idle();
      chk("R9 data", ld_data, 32'hDEAD_B0EF);
    end
  endtask

  task automatic t_hold_order();
    rdata = 32'h1122_3344;
    drive(1, 0, 32'h0000_0700, 2'd0, 0, 1, 32'h0);
    @(negedge clk);
    valid = 1'b0; big = 1'b0;
    #2;
    chk("R12 order held", ld_data, 32'h0000_0011);
    idle();
    chk("R10 single pulse", {31'd0, ld_valid}, 32'd0);
  endtask

  initial begin
    #(8 * 100000);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #3;
    t_reset();
    t_store_byte();
    t_store_half();
    t_store_word();
    t_misalign();
    t_load_byte();
    t_load_half();
    t_load_word();
    t_hold_order();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule